// File: doc/BRIEF.md
# Master sync clock generator

This block runs in the timing master of a group of devices. It turns the local system clock into a slow, square synchronization clock that the other devices use to line up their internal clock phase. The output is the system clock divided by 16, high for eight system-clock periods and low for eight. The output is single-ended; any differential driver sits outside the block.

Software controls three things. An enable starts and stops the generator. An edge-select bit chooses whether the output switches on rising or on falling system-clock edges. A 5-bit delay word shifts the output later in steps of half a system-clock period. The shift is done with digital timing at both clock edges, not with an analog delay line.

The edge select and delay word are applied only at the start of a divider period. The pulse logic also refuses to start a high phase after a low phase that was cut short. Retuning a running generator therefore never produces a runt pulse.

Top module: `syncgen_master`

## Requirements
- R1: While `rst_n` is low, `sync_clk` is low; the low level appears as soon as reset asserts, without waiting for a clock edge. Reset release is synchronized, so the generator may start no earlier than the third rising `clk` edge after `rst_n` goes high.
- R2: A rising `clk` edge at which `gen_en` is sampled low drives `sync_clk` low within half a clock period and returns the divider to its start phase. `sync_clk` never rises unless `gen_en` was high at the preceding rising edge.
- R3: With fixed settings and `gen_en` held high, `sync_clk` has a period of 16 `clk` cycles (32 half-periods). Each high phase lasts exactly 16 half-periods and each low phase exactly 16 half-periods.
- R4: The launch offset, in half-periods, is (`dly_word` + `edge_sel`) mod 32. `edge_sel` = 0 means the output switches on rising `clk` edges when `dly_word` is even. `edge_sel` = 1 adds one half-period, so the output switches on falling edges when `dly_word` is even.
- R5: The first rising edge of `sync_clk` after an enable comes a whole number of half-periods after the first rising `clk` edge at which `gen_en` is sampled high, and that number equals the launch offset of R4.
- R6: `dly_word` and `edge_sel` are sampled only at the first rising `clk` edge of each divider period, which is also the first enabled edge. Changes at any other time do not affect the output until the next such edge.
- R7: While enabled, every high phase of `sync_clk` lasts exactly 16 half-periods and every low phase at least 16. When a new offset would start a high phase fewer than 16 half-periods after the last fall, that rise is skipped and the output stays low until the next period's launch point.
- R8: `dly_word` = 31 with `edge_sel` = 1 gives offset 0, the same waveform as `dly_word` = 0 with `edge_sel` = 0: the first rise coincides with the enabling clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; both edges are used for output timing |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gen_en | input | 1 | Generator enable, synchronous to `clk` |
| edge_sel | input | 1 | Launch edge: 0 rising, 1 falling (adds one half-period) |
| dly_word | input | 5 | Output delay in half-periods of `clk` |
| sync_clk | output | 1 | Divide-by-16 synchronization clock |

## Verification
Each state register has its own signature at the port. A slipped divider phase moves the next rising edge of `sync_clk` away from its launch half-period within one period. A wrong pulse-length counter changes the width of the very next high or low phase. A settings register that loads at the wrong time shifts the output in the same period in which the delay word changes, instead of at the next wrap. The bench compares the output against a half-period reference model after every clock edge. It also measures first-rise latency and pulse widths, so any of these faults appears within 32 half-periods of the stimulus that exposes it.

// File: rtl/syncgen_pkg.sv
package syncgen_pkg;

  // Default divider exponent: output period is 2**DIV_LOG2 system clocks.
  localparam int unsigned DIV_LOG2_DEF = 4;

  // Default width of the half-period delay word.
  localparam int unsigned DLY_W_DEF = 5;

  // Output launch edge selected by the edge-select input.
  typedef enum logic {
    LAUNCH_RISE = 1'b0,
    LAUNCH_FALL = 1'b1
  } launch_edge_e;

endpackage

// File: rtl/syncgen_rst_sync.sv
module syncgen_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/syncgen_phase_core.sv
module syncgen_phase_core #(
  parameter int unsigned DIV_LOG2 = syncgen_pkg::DIV_LOG2_DEF,
  parameter int unsigned DLY_W    = syncgen_pkg::DLY_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_en,
  input  logic             edge_sel,
  input  logic [DLY_W-1:0] dly_word,
  output logic             even_val,
  output logic             odd_val
);

  // Half-period index width and derived pulse constants.
  localparam int unsigned HS_W       = DIV_LOG2 + 1;
  localparam int unsigned HALF_STEPS = 1 << HS_W;
  localparam int unsigned PULSE_HS   = HALF_STEPS / 2;
  localparam logic [HS_W-1:0] LO_MIN  = HS_W'(PULSE_HS);
  localparam logic [HS_W-1:0] HI_LOAD = HS_W'(PULSE_HS - 1);
  localparam logic [HS_W-1:0] ONE_HS  = HS_W'(1);

  typedef struct packed {
    logic            lvl;
    logic [HS_W-1:0] hi;
    logic [HS_W-1:0] lo;
  } step_t;

  // One half-period of the pulse engine: continue a high phase, start one
  // at the launch index after a full-length low phase, or stay low.
  function automatic step_t half_step(step_t s, logic [HS_W-1:0] idx,
                                      logic [HS_W-1:0] off);
    step_t r;
    r = s;
    if (s.hi != '0) begin
      r.lvl = 1'b1;
      r.hi  = s.hi - ONE_HS;
    end else if ((idx == off) && (s.lo >= LO_MIN)) begin
      r.lvl = 1'b1;
      r.hi  = HI_LOAD;
      r.lo  = '0;
    end else begin
      r.lvl = 1'b0;
      if (s.lo < LO_MIN) begin
        r.lo = s.lo + ONE_HS;
      end
    end
    return r;
  endfunction

  syncgen_pkg::launch_edge_e launch_edge;

  logic [DIV_LOG2-1:0] ph_q, ph_d;
  logic [HS_W-1:0]     hi_q, hi_d;
  logic [HS_W-1:0]     lo_q, lo_d;
  logic [HS_W-1:0]     off_q, off_d;
  logic                odd_q, odd_d;
  logic                off_ce;

  logic [HS_W-1:0] off_now;
  logic [HS_W-1:0] off_use;
  logic [HS_W-1:0] idx_even;
  logic [HS_W-1:0] idx_odd;
  step_t           s0, s1, s2;

  always_comb begin
    launch_edge = syncgen_pkg::launch_edge_e'(edge_sel);
    off_now  = HS_W'(dly_word) +
               ((launch_edge == syncgen_pkg::LAUNCH_FALL) ? ONE_HS : '0);
    // Settings are taken only on the first cycle of a divider period.
    off_use  = (ph_q == '0) ? off_now : off_q;
    idx_even = {ph_q, 1'b0};
    idx_odd  = {ph_q, 1'b1};
    s0       = '{lvl: 1'b0, hi: hi_q, lo: lo_q};
    s1       = half_step(s0, idx_even, off_use);
    s2       = half_step(s1, idx_odd, off_use);
  end

  always_comb begin
    off_ce = gen_en;
    off_d  = off_use;
    if (gen_en) begin
      ph_d     = ph_q + 1'b1;
      hi_d     = s2.hi;
      lo_d     = s2.lo;
      odd_d    = s2.lvl;
      even_val = s1.lvl;
    end else begin
      ph_d     = '0;
      hi_d     = '0;
      lo_d     = LO_MIN;
      odd_d    = 1'b0;
      even_val = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      hi_q  <= '0;
      lo_q  <= LO_MIN;
      odd_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      hi_q  <= hi_d;
      lo_q  <= lo_d;
      odd_q <= odd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
    end else if (off_ce) begin
      off_q <= off_d;
    end
  end

  assign odd_val = odd_q;

endmodule

// File: rtl/syncgen_dual_edge_out.sv
module syncgen_dual_edge_out (
  input  logic clk,
  input  logic rst_n,
  input  logic even_val,
  input  logic odd_val,
  output logic sync_clk
);

  // Two toggle flops, one per clock edge; their XOR is the output, so the
  // output path never passes through a mux on the clock itself.
  logic rise_t_q, rise_t_d;
  logic fall_t_q, fall_t_d;

  always_comb begin
    rise_t_d = even_val ^ fall_t_q;
    fall_t_d = odd_val ^ rise_t_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_t_q <= 1'b0;
    end else begin
      rise_t_q <= rise_t_d;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_t_q <= 1'b0;
    end else begin
      fall_t_q <= fall_t_d;
    end
  end

  assign sync_clk = rise_t_q ^ fall_t_q;

endmodule

// File: rtl/syncgen_master.sv
module syncgen_master #(
  parameter int unsigned DIV_LOG2 = syncgen_pkg::DIV_LOG2_DEF,
  parameter int unsigned DLY_W    = syncgen_pkg::DLY_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_en,
  input  logic             edge_sel,
  input  logic [DLY_W-1:0] dly_word,
  output logic             sync_clk
);

  logic rst_sync_n;
  logic even_val;
  logic odd_val;

  syncgen_rst_sync #(
    .STAGES(2)
  ) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  syncgen_phase_core #(
    .DIV_LOG2 (DIV_LOG2),
    .DLY_W    (DLY_W)
  ) u_core (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .gen_en   (gen_en),
    .edge_sel (edge_sel),
    .dly_word (dly_word),
    .even_val (even_val),
    .odd_val  (odd_val)
  );

  syncgen_dual_edge_out u_out (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .even_val (even_val),
    .odd_val  (odd_val),
    .sync_clk (sync_clk)
  );

endmodule

// File: rtl/syncgen_master_chk.sv
module syncgen_master_chk #(
  parameter int unsigned DIV_LOG2 = syncgen_pkg::DIV_LOG2_DEF
) (
  input logic clk,
  input logic rst_n,
  input logic gen_en,
  input logic sync_clk
);

  localparam int unsigned RUN_W = DIV_LOG2 + 1;
  localparam logic [RUN_W-1:0] HALF_CYC = RUN_W'((1 << DIV_LOG2) / 2);
  localparam logic [RUN_W-1:0] RUN_MAX  = '1;

  logic [RUN_W-1:0] hi_run;
  logic [RUN_W-1:0] lo_run;
  logic             en_d1;
  logic             en_d2;
  logic             en_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= HALF_CYC;
      en_d1  <= 1'b0;
      en_d2  <= 1'b0;
    end else begin
      en_d1 <= gen_en;
      en_d2 <= en_d1;
      if (!gen_en) begin
        hi_run <= '0;
        lo_run <= HALF_CYC;
      end else if (sync_clk) begin
        lo_run <= '0;
        if (hi_run != RUN_MAX) hi_run <= hi_run + 1'b1;
      end else begin
        hi_run <= '0;
        if (lo_run != RUN_MAX) lo_run <= lo_run + 1'b1;
      end
    end
  end

  assign en_ok = gen_en && en_d1 && en_d2;

  // R2
  disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(gen_en) |-> !sync_clk);

  // R2
  rise_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_clk) |-> $past(gen_en));

  // R3
  high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_ok && !sync_clk && (hi_run != '0)) |-> (hi_run == HALF_CYC));

  // R7
  low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_ok && sync_clk && (lo_run != '0)) |-> (lo_run >= HALF_CYC));

endmodule

bind syncgen_master syncgen_master_chk #(
  .DIV_LOG2(DIV_LOG2)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .gen_en   (gen_en),
  .sync_clk (sync_clk)
);

// File: tb/sim_syncgen_master.sv
module sim_syncgen_master;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_STEPS = 32;
  localparam int PULSE_HS   = 16;
  localparam int PERIOD_CYC = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gen_en = 1'b0;
  logic       edge_sel = 1'b0;
  logic [4:0] dly_word = 5'd0;
  logic       sync_clk;

  always #(CLK_PERIOD/2) clk = ~clk;

  syncgen_master u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .gen_en   (gen_en),
    .edge_sel (edge_sel),
    .dly_word (dly_word),
    .sync_clk (sync_clk)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;
  string cur_req = "R1";

  // Behavioural reference state (half-period granularity).
  int m_rcnt = 0;
  int m_ph = 0;
  int m_off = 0;
  int m_hi = 0;
  int m_lo = PULSE_HS;
  bit m_live = 0;
  bit m_exp = 0;
  bit m_pend = 0;

  // Port-side measurements.
  int    hs_idx = 0;
  bit    lat_wait = 0;
  int    lat_exp = 0;
  string lat_tag = "R5";
  int    a_hi = 0;
  int    a_lo = PULSE_HS;
  bit    a_prev = 0;

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit m_step(int j);
    if (m_hi > 0) begin
      m_hi--;
      return 1'b1;
    end
    if ((j == m_off) && (m_lo >= PULSE_HS)) begin
      m_hi = PULSE_HS - 1;
      m_lo = 0;
      return 1'b1;
    end
    if (m_lo < PULSE_HS) m_lo++;
    return 1'b0;
  endfunction

  task automatic sample();
    check(cur_req, "sync_clk vs model", int'(sync_clk), int'(m_exp));
    if (!m_live) begin
      a_hi = 0;
      a_lo = PULSE_HS;
    end else if (sync_clk && !a_prev) begin
      check("R7", "low phase >= 16 half-periods before rise", int'(a_lo >= PULSE_HS), 1);
      if (lat_wait) begin
        check(lat_tag, "first rise latency in half-periods", hs_idx, lat_exp);
        lat_wait = 0;
      end
      a_hi = 1;
      a_lo = 0;
    end else if (!sync_clk && a_prev) begin
      check("R3", "high phase length in half-periods", a_hi, PULSE_HS);
      a_hi = 0;
      a_lo = 1;
    end else if (sync_clk) begin
      a_hi++;
    end else if (a_lo < 1000) begin
      a_lo++;
    end
    hs_idx++;
    a_prev = sync_clk;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      bit live_now;
      @(posedge clk);
      if (!rst_n) m_rcnt = 0;
      else if (m_rcnt < 3) m_rcnt++;
      live_now = rst_n && (m_rcnt >= 3) && gen_en;
      if (!live_now) begin
        m_ph = 0; m_hi = 0; m_lo = PULSE_HS; m_exp = 0; m_pend = 0;
      end else begin
        if (!m_live) hs_idx = 0;
        if (m_ph == 0) m_off = (int'(dly_word) + int'(edge_sel)) % HALF_STEPS;
        m_exp  = m_step(2 * m_ph);
        m_pend = m_step(2 * m_ph + 1);
        m_ph   = (m_ph + 1) % PERIOD_CYC;
      end
      m_live = live_now;
      #(CLK_PERIOD/4);
      sample();
      @(negedge clk);
      m_exp = m_pend;
      #(CLK_PERIOD/4);
      sample();
    end
  endtask

  task automatic start(int dly, bit edg, string tag);
    gen_en = 1'b0;
    run(2);
    dly_word = 5'(dly);
    edge_sel = edg;
    lat_exp  = (dly + int'(edg)) % HALF_STEPS;
    lat_tag  = tag;
    lat_wait = 1;
    gen_en   = 1'b1;
  endtask

  initial begin
    // R1: reset holds the output low
    cur_req = "R1";
    run(3);
    check("R1", "sync_clk during reset", int'(sync_clk), 0);
    rst_n = 1'b1;
    // R2: enable low after reset release keeps the output low
    cur_req = "R2";
    run(4);
    check("R2", "sync_clk while disabled", int'(sync_clk), 0);

    // R3 / R5: offset 0, steady running
    cur_req = "R3";
    start(0, 1'b0, "R5");
    run(5 * PERIOD_CYC);
    check("R5", "latency measured", int'(lat_wait), 0);

    // R2: disable in the middle of a high phase
    cur_req = "R2";
    run(3);
    gen_en = 1'b0;
    run(1);
    check("R2", "sync_clk one cycle after disable", int'(sync_clk), 0);
    run(3);

    // R4: falling launch edge plus odd and even delays
    cur_req = "R4";
    start(7, 1'b1, "R4");
    run(3 * PERIOD_CYC);
    check("R4", "latency measured for offset 8", int'(lat_wait), 0);
    start(12, 1'b0, "R4");
    run(3 * PERIOD_CYC);
    start(3, 1'b1, "R5");
    run(3 * PERIOD_CYC);

    // R6: delay word changes inside a period take effect only at the wrap
    cur_req = "R6";
    start(4, 1'b0, "R6");
    run(3);
    dly_word = 5'd20;
    run(PERIOD_CYC);
    for (int k = 0; k < 4 * PERIOD_CYC; k++) begin
      dly_word = 5'((k * 7 + 3) % 32);
      edge_sel = k[2];
      run(1);
    end

    // R7: retune from a late offset to an early one and back
    cur_req = "R7";
    start(20, 1'b0, "R7");
    run(3 * PERIOD_CYC + 5);
    dly_word = 5'd5;
    run(4 * PERIOD_CYC);
    dly_word = 5'd2;
    run(2 * PERIOD_CYC);
    dly_word = 5'd20;
    run(3 * PERIOD_CYC);
    dly_word = 5'd30;
    edge_sel = 1'b1;
    run(3 * PERIOD_CYC);

    // R8: delay 31 with falling edge aliases to offset 0
    cur_req = "R8";
    start(31, 1'b1, "R8");
    run(3 * PERIOD_CYC);

    // R1: asynchronous reset while running forces the output low at once
    cur_req = "R1";
    start(0, 1'b0, "R5");
    run(4);
    check("R1", "sync_clk high before reset", int'(sync_clk), 1);
    rst_n = 1'b0;
    #1;
    check("R1", "sync_clk right after reset assertion", int'(sync_clk), 0);
    run(3);
    rst_n = 1'b1;
    run(2 * PERIOD_CYC);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (R1..R8 run): actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule